// File: doc/BRIEF.md
# Multi-Queue Fall-Through Read Controller

This block drives the read side of a buffer that keeps several logical queues in one shared word memory. A queue is chosen by placing its index on a select bus while a select strobe is high at a clock edge. The first stored word of the chosen queue then moves, without any read request, through a two-register output path and lands on the data output. From that point each read strobe takes the presented word and the next one slides into place. An active-low flag marks whether the data output holds a word that has not been taken yet.

The highest queue index is reserved as a parking queue that never holds data. Selecting it lets the consumer stop partway through a packet. Words of the old queue already inside the output path still reach the data output, but no further words are pulled from memory. Every queue has its own read pointer. When a different real queue is chosen, the pointer of the queue that filled the output path is moved back by the number of words fetched but not taken, so none of them is lost. Selects that come too close together are dropped. The write side supplies one write pointer per queue, and the memory is read through a combinational port addressed by queue index and slot.

Top module: `mq_fwft_rd`

## Requirements
- R1: After reset, `valid_n` is 1, `dout` is 0, the parking queue is the selected queue, and no word is fetched from memory until a real queue is selected.
- R2: A select is taken on a rising clock edge where `sel_en` is 1. When a real queue is taken at edge T, its oldest unread word appears on `dout` with `valid_n` low after edge T+2. After edges T and T+1, `valid_n` is 1.
- R3: A word that reaches an empty output register does so without a read request. While `rd_en_n` is 1, a presented word stays on `dout` and `valid_n` stays low.
- R4: An edge with `rd_en_n` 0 and `valid_n` 0 takes the presented word. If a further word of the queue is available, it is on `dout` after that same edge.
- R5: When the selected queue has no unread word left, taking the last word drives `valid_n` to 1 and `dout` keeps that word. A queue is empty when its read pointer equals its write pointer. When the write pointer then moves ahead, the new word is on `dout` two edges later.
- R6: Index NQ-1 is the parking queue. A select of it stops all fetching from that edge onward, including that edge itself. A word already in the first pipeline register still advances to `dout`, and a read of the last such word leaves `valid_n` at 1 with `dout` held.
- R7: On a select of a real queue, the output path is emptied. The read pointer of the queue that filled it is lowered by the number of words held there and not taken (0, 1 or 2), and a read on that same edge is discarded. A later select of that queue restarts at the first word not taken.
- R8: A select strobe on the edge directly after a taken select is ignored. A select two edges after a taken select is taken.
- R9: Pointers are QAW+1 bits wide and wrap. The memory address is {queue index, pointer mod 2^QAW}, so word k of queue q sits in slot k mod 2^QAW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en_n | input | 1 | Active-low read strobe |
| sel_en | input | 1 | Queue select strobe |
| sel_addr | input | QW | Index of the queue to select |
| wr_ptrs | input | NQ*(QAW+1) | Write pointer of each queue, queue i in bits i*(QAW+1) upward |
| mem_addr | output | QW+QAW | Shared memory read address {queue, slot} |
| mem_rdata | input | DW | Shared memory read data, same cycle as mem_addr |
| dout | output | DW | Output register |
| valid_n | output | 1 | Low while dout holds a word not yet taken |

## Verification
The bench goes after the fall-through latency of exactly two edges. A design that is one register short or one register long presents word 0 a cycle early or late. It also covers the rollback on a switch with zero, one and two words in flight. A design with the wrong rollback count skips or repeats words when a queue is selected again. Parking in the middle of a packet checks that the word in the first register still comes out and that the next word stays in memory; a leaky design returns that word twice or skips it. Back-to-back selects, selects spaced exactly two edges apart, and reads across the slot wrap catch a guard with the wrong window and an address that ignores the pointer's low bits.

// File: rtl/mq_rd_pkg.sv
package mq_rd_pkg;
   // number of words held in the two-stage output path (0..2)
   typedef logic [1:0] pend_t;
endpackage

// File: rtl/mq_sel_guard.sv
module mq_sel_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_en,
   output logic sel_take
);
   logic blocked;

   assign sel_take = sel_en && !blocked;

   always_ff @(posedge clk) begin
      if (!rst_n) blocked <= 1'b0;
      else        blocked <= sel_take;
   end

   // R8: two taken selects are never on adjacent edges
   assert_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_take |=> !sel_take);
endmodule

// File: rtl/mq_ptr_bank.sv
module mq_ptr_bank
   import mq_rd_pkg::*;
#(
   parameter int NQ = 4,
   parameter int PW = 4,
   localparam int QW = $clog2(NQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [QW-1:0]    inc_q,
   input  logic             rb,
   input  logic [QW-1:0]    rb_q,
   input  pend_t            rb_n,
   output logic [NQ*PW-1:0] rd_ptrs
);
   for (genvar i = 0; i < NQ; i++) begin : g_q
      logic [PW-1:0] ptr;
      always_ff @(posedge clk) begin
         if (!rst_n)                       ptr <= '0;
         else if (rb && rb_q == QW'(i))    ptr <= ptr - PW'(rb_n);
         else if (inc && inc_q == QW'(i))  ptr <= ptr + 1'b1;
      end
      assign rd_ptrs[i*PW +: PW] = ptr;
   end

   // R7: rollback and fetch never share an edge
   assert_rb_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rb |-> !inc);
endmodule

// File: rtl/mq_out_pipe.sv
module mq_out_pipe
   import mq_rd_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          rd_en_n,
   input  logic          fetch,
   input  logic [DW-1:0] fetch_data,
   output logic          s1_free,
   output logic          s1_v,
   output logic [DW-1:0] dout,
   output logic          valid_n,
   output pend_t         pend
);
   logic          o_v;
   logic [DW-1:0] s1_d;
   logic          consume, advance;

   assign consume = !rd_en_n && o_v && !flush;
   assign advance = s1_v && (!o_v || consume) && !flush;
   assign s1_free = !s1_v || advance;
   assign valid_n = !o_v;
   assign pend    = pend_t'(s1_v) + pend_t'(o_v);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_v  <= 1'b0;
         s1_v <= 1'b0;
         s1_d <= '0;
         dout <= '0;
      end else if (flush) begin
         o_v  <= 1'b0;
         s1_v <= 1'b0;
      end else begin
         if (advance) begin
            dout <= s1_d;
            o_v  <= 1'b1;
         end else if (consume) begin
            o_v  <= 1'b0;
         end
         if (fetch) begin
            s1_d <= fetch_data;
            s1_v <= 1'b1;
         end else if (advance) begin
            s1_v <= 1'b0;
         end
      end
   end

   // R3: an untaken word stays put while the read strobe is high
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_n && rd_en_n && !flush) |=> (!valid_n && $stable(dout)));
   // R7: a switch empties both stages
   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_n && !s1_v));
   // R5: running dry keeps the last word on the output
   assert_empty_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_n) |-> $stable(dout));
endmodule

// File: rtl/mq_fwft_rd.sv
module mq_fwft_rd
   import mq_rd_pkg::*;
#(
   parameter int DW  = 16,
   parameter int NQ  = 4,
   parameter int QAW = 3,
   localparam int QW    = $clog2(NQ),
   localparam int PW    = QAW + 1,
   localparam int NULLQ = NQ - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en_n,
   input  logic             sel_en,
   input  logic [QW-1:0]    sel_addr,
   input  logic [NQ*PW-1:0] wr_ptrs,
   output logic [QW+QAW-1:0] mem_addr,
   input  logic [DW-1:0]    mem_rdata,
   output logic [DW-1:0]    dout,
   output logic             valid_n
);
   if (NQ < 2 || (1 << QW) != NQ) begin : g_bad_nq
      $error("NQ must be a power of two of at least 2");
   end
   if (QAW < 1 || DW < 1) begin : g_bad_w
      $error("QAW and DW must be at least 1");
   end

   logic            sel_take, take_real, take_null;
   logic [QW-1:0]   cur_q, src_q;
   logic [NQ*PW-1:0] rd_ptrs;
   logic [PW-1:0]   rptr_cur, wptr_cur;
   logic            q_empty, fetch, s1_free, s1_v;
   pend_t           pend;

   mq_sel_guard i_guard (
      .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .sel_take(sel_take));

   assign take_real = sel_take && (sel_addr != QW'(NULLQ));
   assign take_null = sel_take && (sel_addr == QW'(NULLQ));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= QW'(NULLQ);
         src_q <= '0;
      end else if (take_real) begin
         cur_q <= sel_addr;
         src_q <= sel_addr;
      end else if (take_null) begin
         cur_q <= QW'(NULLQ);
      end
   end

   assign rptr_cur = rd_ptrs[int'(cur_q)*PW +: PW];
   assign wptr_cur = wr_ptrs[int'(cur_q)*PW +: PW];
   assign q_empty  = (rptr_cur == wptr_cur);
   assign fetch    = !sel_take && (cur_q != QW'(NULLQ)) && !q_empty && s1_free;
   assign mem_addr = {cur_q, rptr_cur[QAW-1:0]};

   mq_ptr_bank #(.NQ(NQ), .PW(PW)) i_ptrs (
      .clk(clk), .rst_n(rst_n),
      .inc(fetch), .inc_q(cur_q),
      .rb(take_real), .rb_q(src_q), .rb_n(pend),
      .rd_ptrs(rd_ptrs));

   mq_out_pipe #(.DW(DW)) i_pipe (
      .clk(clk), .rst_n(rst_n), .flush(take_real), .rd_en_n(rd_en_n),
      .fetch(fetch), .fetch_data(mem_rdata),
      .s1_free(s1_free), .s1_v(s1_v), .dout(dout), .valid_n(valid_n),
      .pend(pend));

   // R6: while parked, an empty first stage stays empty
   assert_park_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == QW'(NULLQ) && $past(cur_q == QW'(NULLQ)) && !$past(s1_v)) |-> !s1_v);
endmodule

// File: tb/test_mq_fwft_rd.sv
module test_mq_fwft_rd;
   localparam int DW = 16, NQ = 4, QAW = 3, QW = 2, PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0, rd_en_n = 1'b1, sel_en = 1'b0;
   logic [QW-1:0] sel_addr = '0;
   logic [NQ*PW-1:0] wr_ptrs = '0;
   logic [QW+QAW-1:0] mem_addr;
   logic [DW-1:0] mem_rdata, dout;
   logic valid_n;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   // word k of queue q is (q << 12) | (k mod 8)
   assign mem_rdata = {2'b00, mem_addr[4:3], 9'd0, mem_addr[2:0]};

   mq_fwft_rd #(.DW(DW), .NQ(NQ), .QAW(QAW)) i_mq_fwft_rd (
      .clk(clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .sel_en(sel_en),
      .sel_addr(sel_addr), .wr_ptrs(wr_ptrs), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .dout(dout), .valid_n(valid_n));

   function automatic logic [DW-1:0] wd(int q, int k);
      return DW'((q << 12) | (k % 8));
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_out(string req, logic vn, logic [DW-1:0] d);
      total++;
      if (valid_n !== vn || dout !== d) begin
         bad++;
         $display("FAIL %s: valid_n=%0b dout=%h expected valid_n=%0b dout=%h",
                  req, valid_n, dout, vn, d);
      end
   endtask

   task automatic sel(int q);
      sel_en = 1'b1; sel_addr = QW'(q);
      step();
      sel_en = 1'b0;
   endtask

   task automatic rd();
      rd_en_n = 1'b0;
      step();
      rd_en_n = 1'b1;
   endtask

   task automatic set_wp(int q, int v);
      wr_ptrs[q*PW +: PW] = PW'(v);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      set_wp(0, 5); set_wp(1, 3); set_wp(2, 0);
      @(negedge clk);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      expect_out("R1 reset", 1'b1, '0);
      repeat (3) step();
      expect_out("R1 parked after reset", 1'b1, '0);

      // R2 fall-through latency
      sel(0);
      expect_out("R2 edge T", 1'b1, '0);
      step();
      expect_out("R2 edge T+1", 1'b1, '0);
      step();
      expect_out("R2 word0 at T+2", 1'b0, wd(0, 0));

      // R3 hold while read strobe high
      for (int i = 0; i < 3; i++) begin
         step();
         expect_out("R3 hold", 1'b0, wd(0, 0));
      end

      // R4 reads advance
      rd(); expect_out("R4 read 1", 1'b0, wd(0, 1));
      rd(); expect_out("R4 read 2", 1'b0, wd(0, 2));

      // switch with two words in flight, then drain q1
      sel(1); step(); step();
      expect_out("R2 q1 word0", 1'b0, wd(1, 0));
      rd(); expect_out("R4 q1 w1", 1'b0, wd(1, 1));
      rd(); expect_out("R4 q1 w2", 1'b0, wd(1, 2));
      rd(); expect_out("R5 drained", 1'b1, wd(1, 2));
      step(); expect_out("R5 stays drained", 1'b1, wd(1, 2));
      set_wp(1, 4);
      step(); expect_out("R5 new word one edge", 1'b1, wd(1, 2));
      step(); expect_out("R5 new word two edges", 1'b0, wd(1, 3));

      // R7 rollback of q0 by two
      sel(0); step(); step();
      expect_out("R7 q0 resumes at w2", 1'b0, wd(0, 2));

      // R6 park while reading
      rd_en_n = 1'b0; sel_en = 1'b1; sel_addr = QW'(NQ - 1);
      step();
      rd_en_n = 1'b1; sel_en = 1'b0;
      expect_out("R6 prefetched word out", 1'b0, wd(0, 3));
      step(); step();
      expect_out("R6 held", 1'b0, wd(0, 3));
      rd(); expect_out("R6 empty after last", 1'b1, wd(0, 3));
      rd(); rd(); expect_out("R6 reads while parked", 1'b1, wd(0, 3));
      sel(0); step(); step();
      expect_out("R7 q0 after park at w4", 1'b0, wd(0, 4));

      // R8 adjacent select ignored
      set_wp(2, 6);
      sel_en = 1'b1; sel_addr = 2'd1; step();
      sel_addr = 2'd2; step();
      sel_en = 1'b0;
      expect_out("R8 after ignored select", 1'b1, wd(0, 4));
      step();
      expect_out("R8 first select kept", 1'b0, wd(1, 3));

      // R8 select two edges apart is taken
      sel(0); step();
      sel(2);
      step(); expect_out("R8 spaced select T+1", 1'b1, wd(1, 3));
      step(); expect_out("R8 spaced select taken", 1'b0, wd(2, 0));

      // R9 wrap across slots
      for (int k = 1; k < 6; k++) begin
         rd(); expect_out("R9 q2 read", 1'b0, wd(2, k));
      end
      rd(); expect_out("R5 q2 drained", 1'b1, wd(2, 5));
      set_wp(2, 12);
      step(); step();
      expect_out("R9 q2 w6", 1'b0, wd(2, 6));
      for (int k = 7; k < 12; k++) begin
         rd(); expect_out("R9 q2 wrapped read", 1'b0, wd(2, k));
      end
      rd(); expect_out("R9 q2 drained after wrap", 1'b1, wd(2, 11));

      // R7 q0 rolled back by one during the spaced-select test
      sel(0); step(); step();
      expect_out("R7 q0 final resume", 1'b0, wd(0, 4));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule